// File: doc/BRIEF.md
# Display Controller Status and Interrupt Register

This block holds the sticky status flags of a display controller that feeds one or two panels through input and output FIFOs. It watches push and pop strobes together with each FIFO's full and empty indications. It latches an overrun flag when a push meets a full FIFO and an underrun flag when a pop meets an empty one. Two further strobes latch a bus-fault flag and an AC-bias-count flag. Flags that belong to the lower panel are honoured only in dual-panel mode.

Software reads the flags as a 32-bit word and clears an error flag by writing a 1 to its position. The register also carries two handoff flags. The first is a disable-done flag, raised on the first end-of-frame strobe after the controller is switched off. The second is a read-only base-address-update flag, which tracks whether a newly written base address has reached the current-address register. One interrupt line is the registered OR of the live error flags, gated by a single mask input.

Top module: `lcd_stat_reg`

## Requirements
- R1: After reset the read word is 0x00000001 (only the disable-done flag at bit 0 set) and `irq` is 0.
- R2: Bit positions are fixed. The input-FIFO flags are bit 4 (lower overrun), bit 5 (lower underrun), bit 6 (upper overrun) and bit 7 (upper underrun). The output-FIFO flags use the same order at bits 8 to 11. A push while full sets the overrun bit and a pop while empty sets the underrun bit, one clock edge after the strobe. FIFO index 0 is the lower panel and index 1 is the upper panel.
- R3: The lower-panel flags (bits 4, 5, 8, 9) set only while `dual_mode` is 1. The upper-panel flags set in both modes.
- R4: A write clears every error flag (bits 0 and 2 to 11) whose `wr_data` bit is 1. A 0 in `wr_data` leaves the flag unchanged. Bits 12 to 31 always read 0 and writes to them do nothing.
- R5: `irq` is registered. It is 1 after an edge at which any of bits 2 to 11 is set and `err_mask` is 0. Lower-panel bits count only while `dual_mode` is 1. `err_mask` at 1 forces `irq` to 0 from the next edge.
- R6: When a set event and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R7: Bit 1 is read-only. It goes to 0 on `base_wr`. It goes to 1 on a rising edge of `lcd_en` or on `addr_wrap`, and setting wins over `base_wr` in the same cycle. Writes do not change it.
- R8: Bit 0 sets on the first `frame_end` strobe after `lcd_en` falls. It clears while `lcd_en` is 1, and it can also be cleared by writing a 1.
- R9: Bit 2 sets on `bus_fault` and bit 3 sets on `acb_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dual_mode | input | 1 | 1 = two panels, 0 = upper panel only |
| err_mask | input | 1 | 1 masks the interrupt |
| lcd_en | input | 1 | Controller enable |
| frame_end | input | 1 | End-of-frame strobe |
| base_wr | input | 1 | Software wrote a new base address |
| addr_wrap | input | 1 | Current pointer reached the end address |
| bus_fault | input | 1 | Bus error strobe |
| acb_done | input | 1 | AC-bias count expiry strobe |
| in_push | input | 2 | Input FIFO push strobes (0 lower, 1 upper) |
| in_full | input | 2 | Input FIFO full indications |
| in_pop | input | 2 | Input FIFO pop strobes |
| in_empty | input | 2 | Input FIFO empty indications |
| out_push | input | 2 | Output FIFO push strobes |
| out_full | input | 2 | Output FIFO full indications |
| out_pop | input | 2 | Output FIFO pop strobes |
| out_empty | input | 2 | Output FIFO empty indications |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Write data, 1 clears a flag |
| rd_data | output | REG_W | Status word |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the same bit in one cycle: a hardware set event, and the software write-one-to-clear of that bit. The bench provokes this by raising an upper output overrun strobe in the same cycle as a write of 1 to bit 10. The bit must read 1 afterwards. The base-address bit has the same conflict, between `base_wr` and `addr_wrap` asserted together, and the bench expects the bit to read 1 there too.

// File: rtl/lcd_stat_reg.sv
module lcd_stat_reg #(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dual_mode,
  input  logic             err_mask,
  input  logic             lcd_en,
  input  logic             frame_end,
  input  logic             base_wr,
  input  logic             addr_wrap,
  input  logic             bus_fault,
  input  logic             acb_done,
  input  logic [1:0]       in_push,
  input  logic [1:0]       in_full,
  input  logic [1:0]       in_pop,
  input  logic [1:0]       in_empty,
  input  logic [1:0]       out_push,
  input  logic [1:0]       out_full,
  input  logic [1:0]       out_pop,
  input  logic [1:0]       out_empty,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  localparam int NF = 12;

  logic [NF-1:0] flg, set_v, clr_v, nxt;
  logic [1:0]    lane_ok;
  logic [9:0]    qual;
  logic          en_q, dis_pend, armed;

  assign lane_ok = {1'b1, dual_mode};

  genvar p;
  generate
    for (p = 0; p < 2; p++) begin : g_lane
      assign set_v[4+2*p] = in_push[p]  & in_full[p]   & lane_ok[p];
      assign set_v[5+2*p] = in_pop[p]   & in_empty[p]  & lane_ok[p];
      assign set_v[8+2*p] = out_push[p] & out_full[p]  & lane_ok[p];
      assign set_v[9+2*p] = out_pop[p]  & out_empty[p] & lane_ok[p];
    end
  endgenerate

  assign armed    = dis_pend | (en_q & ~lcd_en);
  assign set_v[0] = armed & frame_end & ~lcd_en;
  assign set_v[1] = (lcd_en & ~en_q) | addr_wrap;
  assign set_v[2] = bus_fault;
  assign set_v[3] = acb_done;

  assign clr_v[0]      = (wr_en & wr_data[0]) | lcd_en;
  assign clr_v[1]      = base_wr;
  assign clr_v[NF-1:2] = wr_en ? wr_data[NF-1:2] : '0;

  assign nxt  = set_v | (flg & ~clr_v);
  assign qual = {2'b11, dual_mode, dual_mode, 2'b11, dual_mode, dual_mode, 2'b11};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flg      <= NF'(1);
      en_q     <= 1'b0;
      dis_pend <= 1'b0;
      irq      <= 1'b0;
    end else begin
      flg      <= nxt;
      en_q     <= lcd_en;
      dis_pend <= lcd_en ? 1'b0 : (armed & ~frame_end);
      irq      <= (|(nxt[NF-1:2] & qual)) & ~err_mask;
    end
  end

  assign rd_data = {{(REG_W-NF){1'b0}}, flg};

  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_mask |=> !irq);
  p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[2] && !bus_fault) |=> !rd_data[2]);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_fault && !(wr_en && wr_data[2])) |=> $stable(rd_data[2]));
  p_lower_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_mode && !rd_data[9]) |=> !rd_data[9]);
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_push[1] && out_full[1]) |=> rd_data[10]);
  p_bau_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_wr && !addr_wrap && !lcd_en) |=> $stable(rd_data[1]));
  p_ldd_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |=> !rd_data[0]);
endmodule

// File: tb/tb_lcd_stat_reg.sv
module tb_lcd_stat_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dual_mode = 0, err_mask = 0, lcd_en = 0, frame_end = 0, base_wr = 0;
  logic addr_wrap = 0, bus_fault = 0, acb_done = 0, wr_en = 0;
  logic [1:0] in_push = 0, in_full = 0, in_pop = 0, in_empty = 0;
  logic [1:0] out_push = 0, out_full = 0, out_pop = 0, out_empty = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic irq;
  int errs = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lcd_stat_reg #(.REG_W(32)) dut (.*);

  // {dual, in_push, in_full, in_pop, in_empty, out_push, out_full, out_pop, out_empty, expected bits 11:0}
  localparam logic [28:0] VEC [12] = '{
    {1'b1, 16'h5000, 12'h010}, {1'b0, 16'h5000, 12'h000},
    {1'b1, 16'h0500, 12'h020}, {1'b0, 16'hA000, 12'h040},
    {1'b0, 16'h0A00, 12'h080}, {1'b1, 16'h0050, 12'h100},
    {1'b0, 16'h0005, 12'h000}, {1'b0, 16'h00A0, 12'h400},
    {1'b0, 16'h000A, 12'h800}, {1'b1, 16'h4000, 12'h000},
    {1'b1, 16'hFFFF, 12'hFF0}, {1'b0, 16'hFFFF, 12'hCC0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic quiet();
    {in_push, in_full, in_pop, in_empty, out_push, out_full, out_pop, out_empty} = '0;
    {frame_end, base_wr, addr_wrap, bus_fault, acb_done, wr_en} = '0;
    wr_data = '0;
  endtask

  task automatic clear_all();
    wr_en = 1; wr_data = 32'hFFFF_FFFF; tick(); quiet();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    chk("R1 reset word", rd_data, 32'h1);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    clear_all();
    chk("R4 reserved bits read zero", rd_data, 32'h0);

    for (int i = 0; i < 12; i++) begin
      dual_mode = VEC[i][28];
      {in_push, in_full, in_pop, in_empty, out_push, out_full, out_pop, out_empty} = VEC[i][27:12];
      tick(); quiet();
      chk("R2/R3 fifo flag vector", rd_data, {20'b0, VEC[i][11:0]});
      chk("R5 irq follows flags", {31'b0, irq}, {31'b0, VEC[i][11:0] != 0});
      clear_all();
    end

    // R9 bus fault and AC-bias
    bus_fault = 1; tick(); quiet();
    chk("R9 bus fault bit2", rd_data, 32'h4);
    wr_en = 1; wr_data = 32'h0; tick(); quiet();
    chk("R4 write zero keeps", rd_data, 32'h4);
    wr_en = 1; wr_data = 32'h4; tick(); quiet();
    chk("R4 write one clears", rd_data, 32'h0);
    acb_done = 1; tick(); quiet();
    chk("R9 ac-bias bit3", rd_data, 32'h8);
    clear_all();

    // R5 mask
    err_mask = 1; bus_fault = 1; tick(); quiet();
    chk("R5 masked irq low", {31'b0, irq}, 32'h0);
    err_mask = 0; tick();
    chk("R5 unmasked irq high", {31'b0, irq}, 32'h1);
    clear_all();
    dual_mode = 1; out_push = 2'b01; out_full = 2'b01; tick(); quiet();
    chk("R5 lower flag irq in dual", {31'b0, irq}, 32'h1);
    dual_mode = 0; tick();
    chk("R5 lower flag ignored in single", {31'b0, irq}, 32'h0);
    chk("R3 lower flag kept", rd_data, 32'h100);
    clear_all();

    // R6 set wins
    out_push = 2'b10; out_full = 2'b10; tick(); quiet();
    out_push = 2'b10; out_full = 2'b10; wr_en = 1; wr_data = 32'h400; tick(); quiet();
    chk("R6 set beats clear", rd_data, 32'h400);
    clear_all();

    // R7 base-address handoff
    wr_en = 1; wr_data = 32'h2; tick(); quiet();
    chk("R7 write ignored while 0", rd_data, 32'h0);
    lcd_en = 1; tick();
    chk("R7 enable rise sets", rd_data, 32'h2);
    wr_en = 1; wr_data = 32'hFFFF_FFFF; tick(); quiet();
    chk("R7 write ignored while 1", rd_data, 32'h2);
    base_wr = 1; tick(); quiet();
    chk("R7 base write clears", rd_data, 32'h0);
    addr_wrap = 1; tick(); quiet();
    chk("R7 wrap sets", rd_data, 32'h2);
    base_wr = 1; tick(); quiet();
    base_wr = 1; addr_wrap = 1; tick(); quiet();
    chk("R7 wrap beats base write", rd_data, 32'h2);

    // R8 disable done
    frame_end = 1; tick(); quiet();
    chk("R8 no set while enabled", rd_data, 32'h2);
    lcd_en = 0; tick();
    chk("R8 not yet at fall", rd_data, 32'h2);
    tick();
    chk("R8 waits for frame end", rd_data, 32'h2);
    frame_end = 1; tick(); quiet();
    chk("R8 sets on frame end", rd_data, 32'h3);
    lcd_en = 1; tick();
    chk("R8 re-enable clears", rd_data[0], 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule